// File: doc/BRIEF.md
# Fixed-Configuration SPI Flash Master

This block is a 32-bit Wishbone B3 slave that drives a serial NOR flash over four pads: serial clock, data out, data in and active-low chip selects. Almost every setting a general SPI master would expose is fixed when the block is built. Each transfer moves exactly 32 bits, most significant bit first, in both directions at once. Data out changes on the falling edge of the serial clock. Data in is sampled on the rising edge. The serial clock runs at a fixed division of the bus clock, and that division is set per instance by a 4-bit parameter.

Software sees three registers. The data register takes the next word to send, and reading it returns the last word received. The control register starts a transfer when software writes a word with bit 8 set; its bit 8 then reads back as 1 until the transfer ends. The chip-select register drives the select pads directly. The transmit word resets to the flash read command with address zero, so a boot routine can open a continuous read from address 0 by selecting the device and starting one transfer, with no data write first. It then keeps issuing transfers, and each one returns the next 32 bits of the flash.

Top module: `sflash_master`

## Requirements
- R1: After reset the serial clock is low, data out is low, every chip-select pad is high (inactive), the data register reads 0, the chip-select register reads 0, and the control register reads 0x00000420.
- R2: Every access with cyc and stb both high is acknowledged with a one-cycle ack pulse on the clock edge after the access is accepted. Reads of any word index other than 0 (data), 4 (control) and 6 (chip select) on wb_adr_i[4:2] return 0, and writes to them have no effect.
- R3: A write to the control register (word index 4) with bit 8 set starts a transfer when the block is idle. While a transfer runs, the control register reads 0x00000520. When the transfer ends it reads 0x00000420 again: bit 10 and the length field value 0x20 in bits 6:0 are fixed.
- R4: The serial clock idles low. During a transfer its full period is 2*(DIV+1) bus clocks, starting with a low half. A transfer lasts exactly 64*(DIV+1) bus clocks and ends with the clock low.
- R5: Data out presents the 32 bits of the transmit word MSB first. The first bit appears when the transfer starts, and later bits change only at falling serial-clock edges. Data out is low when idle.
- R6: Data in is sampled at each rising serial-clock edge. After a transfer ends, a read of the data register returns the 32 sampled bits, the first sample in bit 31.
- R7: Writing the chip-select register (word index 6) drives ss_n_o[i] low for each bit i written as 1. The pads change only on such writes and never because of a transfer.
- R8: While a transfer is running, writes to the data register and to the control register are ignored. This includes a write accepted on the same edge on which the transfer ends.
- R9: Without any data write after reset, the first transfer sends 0x03000000.
- R10: A control write with bit 8 clear starts no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_i | input | 1 | Synchronous reset, active high |
| wb_cyc_i | input | 1 | Bus cycle valid |
| wb_stb_i | input | 1 | Strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 3 | Word address, byte address bits 4:2 |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data, valid with ack |
| wb_ack_o | output | 1 | Access acknowledge |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ss_n_o | output | SS_W | Chip selects, active low |

## Verification
Two things can meet on the same bus clock edge: the end of a transfer, which clears busy and loads the receive word, and a bus access that depends on busy. The bench uses its reference model to find the last cycle of a transfer. On exactly that edge it places a data write, then a control write with bit 8 set, then a control read. It judges the result by the next transfer's serial output, by the serial clock staying low afterwards, and by the value the read returns, which must be the pre-edge status and the pre-edge receive word. Its per-cycle model compares all outputs on every clock.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int XFER_BITS = 32;
  localparam int CTRL_GO_BIT = 8;
  localparam int CTRL_TXNEG_BIT = 10;
  localparam logic [2:0] IDX_DATA = 3'd0;
  localparam logic [2:0] IDX_CTRL = 3'd4;
  localparam logic [2:0] IDX_SSEL = 3'd6;
  localparam logic [31:0] TX_RESET_WORD = 32'h0300_0000;

  // Status word seen on control reads.
  function automatic logic [31:0] ctrl_word(input logic busy);
    logic [31:0] w;
    w = '0;
    w[CTRL_TXNEG_BIT] = 1'b1;
    w[CTRL_GO_BIT] = busy;
    w[6:0] = 7'(XFER_BITS);
    return w;
  endfunction

  // Serial shift with sample inserted at the bottom.
  function automatic logic [XFER_BITS-1:0] shift_in(input logic [XFER_BITS-1:0] cur,
                                                    input logic bit_in);
    return {cur[XFER_BITS-2:0], bit_in};
  endfunction
endpackage

// File: rtl/sfm_clkdiv.sv
module sfm_clkdiv #(
  parameter int DIV_W = 4,
  parameter int DIV   = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  logic [DIV_W-1:0] cnt_q;

  assign tick = run && (cnt_q == DIV_W'(DIV));

  always_ff @(posedge clk) begin
    if (rst || !run || tick) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sfm_shifter.sv
module sfm_shifter
  import sfm_pkg::*;
#(
  parameter int W = XFER_BITS
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] tx_word,
  input  logic         tick,
  input  logic         miso,
  output logic         busy,
  output logic         sclk,
  output logic         mosi,
  output logic         done,
  output logic [W-1:0] rx_next
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh_q;
  logic [CW-1:0] bit_q;
  logic          samp_q;
  logic          rise_ev, fall_ev;

  assign rise_ev = busy && tick && !sclk;
  assign fall_ev = busy && tick && sclk;
  assign done    = fall_ev && (bit_q == CW'(W - 1));
  assign rx_next = shift_in(sh_q, samp_q);
  assign mosi    = busy && sh_q[W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sclk   <= 1'b0;
      sh_q   <= '0;
      bit_q  <= '0;
      samp_q <= 1'b0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      sclk  <= 1'b0;
      sh_q  <= tx_word;
      bit_q <= '0;
    end else if (busy && tick) begin
      sclk <= !sclk;
      if (rise_ev) samp_q <= miso;
      if (fall_ev) begin
        sh_q  <= shift_in(sh_q, samp_q);
        bit_q <= bit_q + 1'b1;
        if (done) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sfm_regs.sv
module sfm_regs
  import sfm_pkg::*;
#(
  parameter int SS_W = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cyc,
  input  logic                 stb,
  input  logic                 we,
  input  logic [2:0]           adr,
  input  logic [31:0]          dat_i,
  output logic [31:0]          dat_o,
  output logic                 ack,
  input  logic                 busy,
  input  logic                 done,
  input  logic [XFER_BITS-1:0] rx_next,
  output logic                 start,
  output logic [XFER_BITS-1:0] tx_word,
  output logic [SS_W-1:0]      ss_q
);
  logic                 accept, wr_data, wr_ctrl, wr_ssel;
  logic [XFER_BITS-1:0] rx_q;
  logic [31:0]          rd_val;

  assign accept  = cyc && stb && !ack;
  assign wr_data = accept && we && (adr == IDX_DATA);
  assign wr_ctrl = accept && we && (adr == IDX_CTRL);
  assign wr_ssel = accept && we && (adr == IDX_SSEL);
  assign start   = wr_ctrl && dat_i[CTRL_GO_BIT] && !busy;

  always_comb begin
    case (adr)
      IDX_DATA: rd_val = rx_q;
      IDX_CTRL: rd_val = ctrl_word(busy);
      IDX_SSEL: rd_val = 32'(ss_q);
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ack     <= 1'b0;
      dat_o   <= '0;
      tx_word <= TX_RESET_WORD;
      rx_q    <= '0;
      ss_q    <= '0;
    end else begin
      ack <= accept;
      if (accept) dat_o <= rd_val;
      if (wr_data && !busy) tx_word <= dat_i;
      if (wr_ssel) ss_q <= dat_i[SS_W-1:0];
      if (done) rx_q <= rx_next;
    end
  end
endmodule

// File: rtl/sflash_master.sv
module sflash_master
  import sfm_pkg::*;
#(
  parameter int DIV  = 1,
  parameter int SS_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            wb_cyc_i,
  input  logic            wb_stb_i,
  input  logic            wb_we_i,
  input  logic [4:2]      wb_adr_i,
  input  logic [31:0]     wb_dat_i,
  output logic [31:0]     wb_dat_o,
  output logic            wb_ack_o,
  output logic            sclk_o,
  output logic            mosi_o,
  input  logic            miso_i,
  output logic [SS_W-1:0] ss_n_o
);
  localparam int DIV_W = 4;

  logic                 busy, tick, start_ev, done_ev;
  logic [XFER_BITS-1:0] tx_word, rx_next;
  logic [SS_W-1:0]      ss_q;

  sfm_regs #(.SS_W(SS_W)) u_regs (
    .clk(clk_i), .rst(rst_i), .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
    .adr(wb_adr_i), .dat_i(wb_dat_i), .dat_o(wb_dat_o), .ack(wb_ack_o),
    .busy(busy), .done(done_ev), .rx_next(rx_next), .start(start_ev),
    .tx_word(tx_word), .ss_q(ss_q)
  );

  sfm_clkdiv #(.DIV_W(DIV_W), .DIV(DIV)) u_div (
    .clk(clk_i), .rst(rst_i), .run(busy), .tick(tick)
  );

  sfm_shifter #(.W(XFER_BITS)) u_shift (
    .clk(clk_i), .rst(rst_i), .start(start_ev), .tx_word(tx_word), .tick(tick),
    .miso(miso_i), .busy(busy), .sclk(sclk_o), .mosi(mosi_o), .done(done_ev),
    .rx_next(rx_next)
  );

  assign ss_n_o = ~ss_q;
endmodule

// File: rtl/sfm_checker.sv
module sfm_checker #(
  parameter int SS_W = 2
) (
  input logic            clk,
  input logic            rst,
  input logic            cyc,
  input logic            stb,
  input logic            we,
  input logic [2:0]      adr,
  input logic            ack,
  input logic            sclk,
  input logic            mosi,
  input logic [SS_W-1:0] ss_n,
  input logic            busy,
  input logic            start_ev,
  input logic            done_ev,
  input logic [31:0]     tx_word
);
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (rst) ack |=> !ack);
  p_ack_follows_r2: assert property (@(posedge clk) disable iff (rst)
    (cyc && stb && !ack) |=> ack);
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (rst) !busy |-> !sclk);
  p_end_low_r4: assert property (@(posedge clk) disable iff (rst)
    done_ev |=> (!busy && !sclk));
  p_start_busy_r3: assert property (@(posedge clk) disable iff (rst) start_ev |=> busy);
  p_mosi_rise_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && $rose(sclk)) |-> $stable(mosi));
  p_mosi_idle_r5: assert property (@(posedge clk) disable iff (rst) !busy |-> !mosi);
  p_ss_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !(cyc && stb && we && !ack && adr == 3'd6) |=> $stable(ss_n));
  p_busy_wr_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && cyc && stb && we && !ack && adr == 3'd0) |=> $stable(tx_word));
endmodule

bind sflash_master sfm_checker #(.SS_W(SS_W)) u_chk (
  .clk(clk_i), .rst(rst_i), .cyc(wb_cyc_i), .stb(wb_stb_i), .we(wb_we_i),
  .adr(wb_adr_i), .ack(wb_ack_o), .sclk(sclk_o), .mosi(mosi_o), .ss_n(ss_n_o),
  .busy(busy), .start_ev(start_ev), .done_ev(done_ev), .tx_word(tx_word)
);

// File: tb/tb_sflash_master.sv
module tb_sflash_master;
  localparam int D = 2;
  localparam int SSW = 2;
  localparam int HALF = D + 1;
  localparam int XLEN = 64 * (D + 1);

  logic clk = 0, rst = 1;
  logic cyc = 0, stb = 0, we = 0, miso = 0;
  logic [2:0] adr = 0;
  logic [31:0] wdat = 0, rdat;
  logic ack, sclk, mosi;
  logic [SSW-1:0] ss_n;

  int n_chk = 0, n_fail = 0, cycles = 0;

  always #4 clk = ~clk;

  sflash_master #(.DIV(D), .SS_W(SSW)) dut (
    .clk_i(clk), .rst_i(rst), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
    .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(miso), .ss_n_o(ss_n)
  );

  // Behavioural reference model
  bit m_ack, m_busy;
  int m_k;
  logic [31:0] m_tx, m_sh, m_rx, m_dat, slv, slv_cur;
  logic [SSW-1:0] m_ss;

  always @(posedge clk) begin
    bit acc, was_busy;
    if (rst) begin
      m_ack = 0; m_busy = 0; m_k = 0; m_tx = 32'h0300_0000; m_sh = 0;
      m_rx = 0; m_dat = 0; m_ss = 0;
    end else begin
      acc = cyc && stb && !m_ack;
      was_busy = m_busy;
      if (acc) begin
        case (adr)
          3'd0: m_dat = m_rx;
          3'd4: m_dat = 32'h420 | (was_busy ? 32'h100 : 32'h0);
          3'd6: m_dat = 32'(m_ss);
          default: m_dat = 0;
        endcase
      end
      if (was_busy) begin
        m_k++;
        if (m_k == XLEN) begin m_busy = 0; m_rx = slv_cur; end
      end
      if (acc && we && !was_busy && adr == 3'd0) m_tx = wdat;
      if (acc && we && adr == 3'd6) m_ss = wdat[SSW-1:0];
      if (acc && we && !was_busy && adr == 3'd4 && wdat[8]) begin
        m_busy = 1; m_k = 0; m_sh = m_tx; slv_cur = slv;
      end
      m_ack = acc;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle compare and serial slave drive, away from the active edge
  always @(negedge clk) begin
    logic exp_sclk, exp_mosi;
    cycles++;
    if (!rst) begin
      exp_sclk = m_busy ? 1'((m_k / HALF) % 2) : 1'b0;
      exp_mosi = m_busy ? m_sh[31 - m_k / (2 * HALF)] : 1'b0;
      chk(sclk == exp_sclk, "R4 sclk", 32'(sclk), 32'(exp_sclk));
      chk(mosi == exp_mosi, "R5 mosi", 32'(mosi), 32'(exp_mosi));
      chk(ss_n == ~m_ss, "R7 ss_n", 32'(ss_n), 32'(~m_ss));
      chk(ack == m_ack, "R2 ack", 32'(ack), 32'(m_ack));
      if (ack) chk(rdat == m_dat, "R6 read data", rdat, m_dat);
    end
    miso = m_busy ? slv_cur[31 - m_k / (2 * HALF)] : 1'b0;
  end

  logic [31:0] col;
  always @(posedge sclk) col = {col[30:0], mosi};

  // Bus tasks: called right after a falling clock edge
  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
    do @(negedge clk); while (!ack);
    cyc = 0; stb = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    cyc = 1; stb = 1; we = 0; adr = a;
    do @(negedge clk); while (!ack);
    d = rdat; cyc = 0; stb = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    do bus_rd(3'd4, v); while (v == 32'h520);
  endtask

  initial begin
    logic [31:0] v;
    slv = 32'hA5C3_1E77; slv_cur = 0; col = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(sclk == 0 && mosi == 0, "R1 pads idle", {sclk, mosi}, 0);
    chk(ss_n == '1, "R1 ss_n", 32'(ss_n), 32'(2'b11));
    bus_rd(3'd0, v); chk(v == 0, "R1 data", v, 0);
    bus_rd(3'd4, v); chk(v == 32'h420, "R1 ctrl", v, 32'h420);
    bus_rd(3'd6, v); chk(v == 0, "R1 ssel", v, 0);
    // R2 unmapped
    bus_wr(3'd2, 32'hFFFF_FFFF);
    bus_rd(3'd2, v); chk(v == 0, "R2 unmapped", v, 0);
    // R7 selects
    bus_wr(3'd6, 32'h1);
    chk(ss_n == 2'b10, "R7 select0", 32'(ss_n), 32'(2'b10));
    // R9 default command, R3 busy readback, R6 receive
    bus_wr(3'd4, 32'h520);
    bus_rd(3'd4, v); chk(v == 32'h520, "R3 busy read", v, 32'h520);
    bus_wr(3'd0, 32'hFFFF_FFFF);          // R8 ignored while busy
    bus_wr(3'd4, 32'h520);                // R8 ignored while busy
    wait_idle();
    chk(col == 32'h0300_0000, "R9 first command", col, 32'h0300_0000);
    chk(ss_n == 2'b10, "R7 held across transfer", 32'(ss_n), 32'(2'b10));
    bus_rd(3'd0, v); chk(v == 32'hA5C3_1E77, "R6 rx word", v, 32'hA5C3_1E77);
    bus_rd(3'd4, v); chk(v == 32'h420, "R3 idle read", v, 32'h420);
    // R8 data write while busy was dropped: command repeats
    slv = 32'h0F0F_3C3C;
    bus_wr(3'd4, 32'h520);
    wait_idle();
    chk(col == 32'h0300_0000, "R8 busy data write ignored", col, 32'h0300_0000);
    bus_rd(3'd0, v); chk(v == 32'h0F0F_3C3C, "R6 second rx", v, 32'h0F0F_3C3C);
    // R10 no start without go bit
    bus_wr(3'd4, 32'h420);
    repeat (3 * HALF) begin
      @(negedge clk); chk(sclk == 0, "R10 no start", 32'(sclk), 0);
    end
    // New word, then writes on the exact finishing edge
    bus_wr(3'd0, 32'h1234_5678);
    slv = 32'hDEAD_BEEF;
    bus_wr(3'd4, 32'h520);
    while (m_k != XLEN - 1) @(negedge clk);
    bus_wr(3'd0, 32'h0000_FFFF);          // R8 coincides with end
    wait_idle();
    chk(col == 32'h1234_5678, "R5 loaded word", col, 32'h1234_5678);
    slv = 32'h8000_0001;
    bus_wr(3'd4, 32'h520);
    wait_idle();
    chk(col == 32'h1234_5678, "R8 end-edge data write ignored", col, 32'h1234_5678);
    bus_wr(3'd4, 32'h520);
    while (m_k != XLEN - 1) @(negedge clk);
    bus_wr(3'd4, 32'h520);                // R8 start on end edge ignored
    repeat (3 * HALF) begin
      @(negedge clk); chk(sclk == 0, "R8 end-edge start ignored", 32'(sclk), 0);
    end
    bus_rd(3'd4, v); chk(v == 32'h420, "R3 idle after", v, 32'h420);
    // Read coinciding with the end edge sees old status
    bus_wr(3'd4, 32'h520);
    while (m_k != XLEN - 1) @(negedge clk);
    bus_rd(3'd4, v); chk(v == 32'h520, "R3 read on end edge", v, 32'h520);
    bus_wr(3'd6, 32'h2);
    chk(ss_n == 2'b01, "R7 select1", 32'(ss_n), 32'(2'b01));
    bus_wr(3'd6, 32'h0);
    chk(ss_n == 2'b11, "R7 release", 32'(ss_n), 32'(2'b11));
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected<150000", cycles);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule